// File: doc/BRIEF.md
# Interrupt Controller Base and Identifier Registers

This block holds two registers of a per-processor interrupt controller. The first is the base-address control register. It carries the memory window address, a global enable, an extended-addressing mode bit and a boot-processor flag. The second is the controller identifier. The identifier has two parts: a full-width initial value, loaded at configuration time, and an 8-bit working value that software may rewrite while the controller is in legacy mode.

The block applies the reset values for a full reset and for an INIT reset. A separate input designates the processor as the boot processor, and the boot flag survives a full reset. When software switches the controller from legacy into extended mode, the working identifier is restored to its initial value. The identifier read port returns the full initial value in extended mode and the zero-extended working value in legacy mode. The block also drives a wait-for-startup flag, which an INIT reset sets on every processor except the boot processor.

All writes take effect on the clock edge that follows the strobe. Both read ports are combinational from the registered state.

Top module: `intc_base_id_regs`

## Requirements
- R1: After the power-on reset (`rst_n` low), the base register reads 0xFEE00800. In that value the boot flag (bit 8) and extended mode (bit 10) are clear, and the enable bit (bit 11) is set. The identifier reads `INIT_ID`, whose default is 0, and the wait-for-startup flag is 1.
- R2: One edge after a full reset, the base register holds the default address 0xFEE00000 with the enable bit (bit 11) set and extended mode (bit 10) clear. Bit 8 keeps the value it had before the full reset. A full reset overrides any base write or boot designation presented in the same cycle.
- R3: A full reset reloads the working identifier from the low 8 bits of the initial identifier. It also sets the wait-for-startup flag to the inverse of the boot flag.
- R4: A base write updates bits 35:12 (address), bit 11 (enable) and bit 10 (extended mode) from the written data on the next edge. Bit 8 is unaffected by the write. Bits 9 and 7:0 always read 0.
- R5: The boot designate input sets or clears bit 8 only. When a base write arrives in the same cycle, the designated value of bit 8 takes precedence over the write.
- R6: A base write that sets bit 10 while bit 10 is currently clear restores the working identifier to the low 8 bits of the initial identifier.
- R7: While bit 10 is set, the identifier read port returns the full 32-bit initial identifier. While bit 10 is clear, it returns the 8-bit working identifier, zero-extended.
- R8: A configuration identifier load sets the initial identifier to the full 32-bit value and the working identifier to its low 8 bits. It takes precedence over a restore (R6) in the same cycle.
- R9: A legacy identifier write replaces the working identifier when bit 10 is clear. It is ignored while bit 10 is set.
- R10: An INIT reset sets the wait-for-startup flag to 1 when bit 8 is clear and to 0 when bit 8 is set. It leaves the base register and both identifiers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| full_rst_i | input | 1 | Synchronous full reset of the controller |
| init_rst_i | input | 1 | Synchronous INIT reset |
| base_we_i | input | 1 | Base register write strobe |
| base_wdata_i | input | 36 | Base register write data |
| base_rdata_o | output | 36 | Base register readback |
| bsp_we_i | input | 1 | Boot designation strobe |
| bsp_val_i | input | 1 | Boot designation value |
| cfg_id_we_i | input | 1 | Configuration identifier load strobe |
| cfg_id_i | input | 32 | Configuration identifier value |
| lid_we_i | input | 1 | Legacy identifier write strobe |
| lid_wdata_i | input | 8 | Legacy identifier write value |
| id_rdata_o | output | 32 | Identifier readback |
| wait_startup_o | output | 1 | Wait-for-startup flag |

## Verification
The assertions assume that every strobe is a clean, level-valid signal, sampled at the rising edge. They also assume that simultaneous strobes resolve by the fixed priority: full reset first, then configuration load or boot designation, then write. The properties therefore exclude the cycles in which a higher-priority input is active. The bench drives all inputs on the falling edge and releases them one cycle later, so each strobe lasts exactly one edge. It combines strobes in one cycle only in the directed cases that test those precedences.

// File: rtl/intc_bid_pkg.sv
package intc_bid_pkg;

   localparam int DEF_BASE_W  = 36;
   localparam int DEF_ID_W    = 32;
   localparam int DEF_WID_W   = 8;
   localparam int DEF_BSP_BIT = 8;
   localparam int DEF_EXT_BIT = 10;
   localparam int DEF_EN_BIT  = 11;
   localparam int DEF_ADDR_LO = 12;

   // source selected for the working identifier on the next edge
   typedef enum logic [1:0] {
      WID_HOLD    = 2'd0,
      WID_CFG     = 2'd1,
      WID_RESTORE = 2'd2,
      WID_SW      = 2'd3
   } wid_src_e;

endpackage

// File: rtl/intc_bid_base_reg.sv
module intc_bid_base_reg
   import intc_bid_pkg::*;
#(
   parameter int BASE_W  = DEF_BASE_W,
   parameter int BSP_BIT = DEF_BSP_BIT,
   parameter int EXT_BIT = DEF_EXT_BIT,
   parameter int EN_BIT  = DEF_EN_BIT,
   parameter int ADDR_LO = DEF_ADDR_LO,
   parameter logic [BASE_W-1:0] DEFAULT_BASE = 'hFEE00000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              full_rst,
   input  logic              wr_en,
   input  logic [BASE_W-1:0] wr_data,
   input  logic              bsp_we,
   input  logic              bsp_val,
   output logic [BASE_W-1:0] base_q,
   output logic              ext_rise,
   output logic              ext_q,
   output logic              bsp_q
);

   localparam logic [BASE_W-1:0] ONE       = {{(BASE_W-1){1'b0}}, 1'b1};
   localparam logic [BASE_W-1:0] ADDR_MASK = ~((ONE << ADDR_LO) - ONE);
   localparam logic [BASE_W-1:0] EN_MASK   = ONE << EN_BIT;
   localparam logic [BASE_W-1:0] BSP_MASK  = ONE << BSP_BIT;
   localparam logic [BASE_W-1:0] RST_VAL   = (DEFAULT_BASE & ADDR_MASK) | EN_MASK;

   logic [BASE_W-1:0] wr_mask;
   logic [BASE_W-1:0] base_d;

   for (genvar b = 0; b < BASE_W; b++) begin : g_wmask
      if (b >= ADDR_LO || b == EXT_BIT || b == EN_BIT) begin : g_rw
         assign wr_mask[b] = 1'b1;
      end else begin : g_ro
         assign wr_mask[b] = 1'b0;
      end
   end

   always_comb begin
      base_d = base_q;
      if (wr_en) begin
         base_d = (wr_data & wr_mask) | (base_q & BSP_MASK);
      end
      if (bsp_we) begin
         base_d[BSP_BIT] = bsp_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= RST_VAL;
      end else if (full_rst) begin
         base_q <= RST_VAL | (base_q & BSP_MASK);
      end else begin
         base_q <= base_d;
      end
   end

   assign ext_q    = base_q[EXT_BIT];
   assign bsp_q    = base_q[BSP_BIT];
   assign ext_rise = wr_en && wr_data[EXT_BIT] && !base_q[EXT_BIT];

   // R2
   full_keeps_bsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_rst |=> (base_q[BSP_BIT] == $past(base_q[BSP_BIT])) && base_q[EN_BIT] && !base_q[EXT_BIT]);

   // R5
   bsp_designate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bsp_we && !full_rst) |=> (base_q[BSP_BIT] == $past(bsp_val)));

   // R4
   write_keeps_bsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !bsp_we && !full_rst) |=> (base_q[BSP_BIT] == $past(base_q[BSP_BIT])));

   // R4
   write_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full_rst) |=> (base_q[EXT_BIT] == $past(wr_data[EXT_BIT])));

endmodule

// File: rtl/intc_bid_id_reg.sv
module intc_bid_id_reg
   import intc_bid_pkg::*;
#(
   parameter int ID_W  = DEF_ID_W,
   parameter int WID_W = DEF_WID_W,
   parameter logic [ID_W-1:0] INIT_ID = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             full_rst,
   input  logic             cfg_we,
   input  logic [ID_W-1:0]  cfg_id,
   input  logic             sw_we,
   input  logic [WID_W-1:0] sw_id,
   input  logic             ext_rise,
   input  logic             ext_q,
   output logic [ID_W-1:0]  id_rd
);

   logic [ID_W-1:0]  init_q;
   logic [WID_W-1:0] work_q;
   wid_src_e         src;

   always_comb begin
      src = WID_HOLD;
      if (cfg_we) begin
         src = WID_CFG;
      end else if (ext_rise) begin
         src = WID_RESTORE;
      end else if (sw_we && !ext_q) begin
         src = WID_SW;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= INIT_ID;
         work_q <= INIT_ID[WID_W-1:0];
      end else if (full_rst) begin
         work_q <= init_q[WID_W-1:0];
      end else begin
         if (cfg_we) begin
            init_q <= cfg_id;
         end
         case (src)
            WID_CFG:     work_q <= cfg_id[WID_W-1:0];
            WID_RESTORE: work_q <= init_q[WID_W-1:0];
            WID_SW:      work_q <= sw_id;
            default:     work_q <= work_q;
         endcase
      end
   end

   if (WID_W == ID_W) begin : g_rd_same
      assign id_rd = ext_q ? init_q : work_q;
   end else begin : g_rd_ext
      assign id_rd = ext_q ? init_q : {{(ID_W-WID_W){1'b0}}, work_q};
   end

   // R6
   restore_on_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_rise && !cfg_we && !full_rst) |=> (work_q == $past(init_q[WID_W-1:0])));

   // R3
   full_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_rst |=> (work_q == $past(init_q[WID_W-1:0])));

   // R9
   sw_ignored_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && ext_q && !cfg_we && !full_rst) |=> $stable(work_q));

   // R8
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !full_rst) |=> (init_q == $past(cfg_id)) && (work_q == $past(cfg_id[WID_W-1:0])));

endmodule

// File: rtl/intc_bid_wait_flag.sv
module intc_bid_wait_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic full_rst,
   input  logic init_rst,
   input  logic bsp_q,
   output logic wait_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= 1'b1;
      end else if (full_rst || init_rst) begin
         wait_q <= !bsp_q;
      end
   end

   // R10
   init_sets_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_rst || init_rst) |=> (wait_q == !$past(bsp_q)));

   // R10
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_rst || init_rst) |=> $stable(wait_q));

endmodule

// File: rtl/intc_base_id_regs.sv
module intc_base_id_regs
   import intc_bid_pkg::*;
#(
   parameter int BASE_W  = DEF_BASE_W,
   parameter int ID_W    = DEF_ID_W,
   parameter int WID_W   = DEF_WID_W,
   parameter int BSP_BIT = DEF_BSP_BIT,
   parameter int EXT_BIT = DEF_EXT_BIT,
   parameter int EN_BIT  = DEF_EN_BIT,
   parameter int ADDR_LO = DEF_ADDR_LO,
   parameter logic [BASE_W-1:0] DEFAULT_BASE = 'hFEE00000,
   parameter logic [ID_W-1:0]   INIT_ID      = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              full_rst_i,
   input  logic              init_rst_i,
   input  logic              base_we_i,
   input  logic [BASE_W-1:0] base_wdata_i,
   output logic [BASE_W-1:0] base_rdata_o,
   input  logic              bsp_we_i,
   input  logic              bsp_val_i,
   input  logic              cfg_id_we_i,
   input  logic [ID_W-1:0]   cfg_id_i,
   input  logic              lid_we_i,
   input  logic [WID_W-1:0]  lid_wdata_i,
   output logic [ID_W-1:0]   id_rdata_o,
   output logic              wait_startup_o
);

   if (BSP_BIT == EXT_BIT || BSP_BIT == EN_BIT || EXT_BIT == EN_BIT) begin : g_bad_bits
      $error("control bit positions must be distinct");
   end
   if (EN_BIT >= ADDR_LO || EXT_BIT >= ADDR_LO || BSP_BIT >= ADDR_LO || ADDR_LO >= BASE_W) begin : g_bad_addr
      $error("control bits must sit below the address field inside the register");
   end
   if (WID_W > ID_W || WID_W < 1) begin : g_bad_id
      $error("working identifier width must be 1..ID_W");
   end

   logic ext_rise;
   logic ext_q;
   logic bsp_q;

   intc_bid_base_reg #(
      .BASE_W      (BASE_W),
      .BSP_BIT     (BSP_BIT),
      .EXT_BIT     (EXT_BIT),
      .EN_BIT      (EN_BIT),
      .ADDR_LO     (ADDR_LO),
      .DEFAULT_BASE(DEFAULT_BASE)
   ) base_u (
      .clk     (clk),
      .rst_n   (rst_n),
      .full_rst(full_rst_i),
      .wr_en   (base_we_i),
      .wr_data (base_wdata_i),
      .bsp_we  (bsp_we_i),
      .bsp_val (bsp_val_i),
      .base_q  (base_rdata_o),
      .ext_rise(ext_rise),
      .ext_q   (ext_q),
      .bsp_q   (bsp_q)
   );

   intc_bid_id_reg #(
      .ID_W   (ID_W),
      .WID_W  (WID_W),
      .INIT_ID(INIT_ID)
   ) id_u (
      .clk     (clk),
      .rst_n   (rst_n),
      .full_rst(full_rst_i),
      .cfg_we  (cfg_id_we_i),
      .cfg_id  (cfg_id_i),
      .sw_we   (lid_we_i),
      .sw_id   (lid_wdata_i),
      .ext_rise(ext_rise),
      .ext_q   (ext_q),
      .id_rd   (id_rdata_o)
   );

   intc_bid_wait_flag wait_u (
      .clk     (clk),
      .rst_n   (rst_n),
      .full_rst(full_rst_i),
      .init_rst(init_rst_i),
      .bsp_q   (bsp_q),
      .wait_q  (wait_startup_o)
   );

endmodule

// File: tb/intc_base_id_regs_tb_top.sv
`timescale 1ns/1ps
module intc_base_id_regs_tb_top;

   localparam logic [2:0] OP_CFG   = 3'd0;
   localparam logic [2:0] OP_WBASE = 3'd1;
   localparam logic [2:0] OP_WID   = 3'd2;
   localparam logic [2:0] OP_BSP   = 3'd3;
   localparam logic [2:0] OP_FULL  = 3'd4;
   localparam logic [2:0] OP_INIT  = 3'd5;

   typedef struct packed {
      logic [2:0]  op;
      logic [35:0] data;
      logic [35:0] ebase;
      logic [31:0] eid;
      logic        ewait;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{OP_CFG,   36'h0_0001_2345, 36'h0_FEE0_0800, 32'h45,    1'b1, 4'd8},  // R8
      '{OP_BSP,   36'h1,           36'h0_FEE0_0900, 32'h45,    1'b1, 4'd5},  // R5
      '{OP_INIT,  36'h0,           36'h0_FEE0_0900, 32'h45,    1'b0, 4'd10}, // R10
      '{OP_WID,   36'h7A,          36'h0_FEE0_0900, 32'h7A,    1'b0, 4'd9},  // R9
      '{OP_WBASE, 36'h1_2340_0800, 36'h1_2340_0900, 32'h7A,    1'b0, 4'd4},  // R4
      '{OP_WBASE, 36'h1_2340_0EFF, 36'h1_2340_0D00, 32'h12345, 1'b0, 4'd6},  // R6 R4 R7
      '{OP_WID,   36'h99,          36'h1_2340_0D00, 32'h12345, 1'b0, 4'd9},  // R9
      '{OP_WBASE, 36'h1_2340_0C00, 36'h1_2340_0D00, 32'h12345, 1'b0, 4'd4},  // R4
      '{OP_WBASE, 36'h0_FEE0_0800, 36'h0_FEE0_0900, 32'h45,    1'b0, 4'd7},  // R7 R6
      '{OP_WID,   36'h3C,          36'h0_FEE0_0900, 32'h3C,    1'b0, 4'd9},  // R9
      '{OP_WBASE, 36'h0_FEE0_0C00, 36'h0_FEE0_0D00, 32'h12345, 1'b0, 4'd6},  // R6
      '{OP_BSP,   36'h0,           36'h0_FEE0_0C00, 32'h12345, 1'b0, 4'd5},  // R5
      '{OP_FULL,  36'h0,           36'h0_FEE0_0800, 32'h45,    1'b1, 4'd2},  // R2 R3
      '{OP_BSP,   36'h1,           36'h0_FEE0_0900, 32'h45,    1'b1, 4'd5},  // R5
      '{OP_WID,   36'h11,          36'h0_FEE0_0900, 32'h11,    1'b1, 4'd9},  // R9
      '{OP_FULL,  36'h0,           36'h0_FEE0_0900, 32'h45,    1'b0, 4'd3},  // R3 R2
      '{OP_INIT,  36'h0,           36'h0_FEE0_0900, 32'h45,    1'b0, 4'd10}, // R10
      '{OP_BSP,   36'h0,           36'h0_FEE0_0800, 32'h45,    1'b0, 4'd5},  // R5
      '{OP_INIT,  36'h0,           36'h0_FEE0_0800, 32'h45,    1'b1, 4'd10}  // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        full_rst_i = 1'b0;
   logic        init_rst_i = 1'b0;
   logic        base_we_i = 1'b0;
   logic [35:0] base_wdata_i = '0;
   logic [35:0] base_rdata_o;
   logic        bsp_we_i = 1'b0;
   logic        bsp_val_i = 1'b0;
   logic        cfg_id_we_i = 1'b0;
   logic [31:0] cfg_id_i = '0;
   logic        lid_we_i = 1'b0;
   logic [7:0]  lid_wdata_i = '0;
   logic [31:0] id_rdata_o;
   logic        wait_startup_o;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   intc_base_id_regs dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .full_rst_i    (full_rst_i),
      .init_rst_i    (init_rst_i),
      .base_we_i     (base_we_i),
      .base_wdata_i  (base_wdata_i),
      .base_rdata_o  (base_rdata_o),
      .bsp_we_i      (bsp_we_i),
      .bsp_val_i     (bsp_val_i),
      .cfg_id_we_i   (cfg_id_we_i),
      .cfg_id_i      (cfg_id_i),
      .lid_we_i      (lid_we_i),
      .lid_wdata_i   (lid_wdata_i),
      .id_rdata_o    (id_rdata_o),
      .wait_startup_o(wait_startup_o)
   );

   task automatic chk(input string tag, input string what, input logic [35:0] act, input logic [35:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_all(input string tag, input logic [35:0] eb, input logic [31:0] ei, input logic ew);
      chk(tag, "base", base_rdata_o, eb);
      chk(tag, "id", {4'h0, id_rdata_o}, {4'h0, ei});
      chk(tag, "wait", {35'h0, wait_startup_o}, {35'h0, ew});
   endtask

   task automatic release_all();
      full_rst_i = 1'b0; init_rst_i = 1'b0; base_we_i = 1'b0;
      bsp_we_i = 1'b0; cfg_id_we_i = 1'b0; lid_we_i = 1'b0;
   endtask

   task automatic drive_op(input logic [2:0] op, input logic [35:0] d);
      case (op)
         OP_CFG:   begin cfg_id_we_i = 1'b1; cfg_id_i = d[31:0]; end
         OP_WBASE: begin base_we_i = 1'b1; base_wdata_i = d; end
         OP_WID:   begin lid_we_i = 1'b1; lid_wdata_i = d[7:0]; end
         OP_BSP:   begin bsp_we_i = 1'b1; bsp_val_i = d[0]; end
         OP_FULL:  full_rst_i = 1'b1;
         OP_INIT:  init_rst_i = 1'b1;
         default:  ;
      endcase
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1", 36'h0_FEE0_0800, 32'h0, 1'b1); // R1 power-on values

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive_op(VECS[i].op, VECS[i].data);
         @(negedge clk);
         release_all();
         chk_all($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i].ebase, VECS[i].eid, VECS[i].ewait);
      end

      // R5: designation wins over bit 8 of a same-cycle write; ext rises too
      @(negedge clk);
      drive_op(OP_WBASE, 36'h0_FEE0_0C00);
      drive_op(OP_BSP, 36'h1);
      @(negedge clk);
      release_all();
      chk_all("R5 with write", 36'h0_FEE0_0D00, 32'h12345, 1'b1);

      // R2: full reset overrides a same-cycle write
      @(negedge clk);
      drive_op(OP_WBASE, 36'h0);
      drive_op(OP_FULL, 36'h0);
      @(negedge clk);
      release_all();
      chk_all("R2 over write", 36'h0_FEE0_0900, 32'h45, 1'b0);

      // R9 legacy write, then R8 config load beats a same-cycle restore
      @(negedge clk);
      drive_op(OP_WID, 36'h66);
      @(negedge clk);
      release_all();
      chk_all("R9 legacy", 36'h0_FEE0_0900, 32'h66, 1'b0);

      @(negedge clk);
      drive_op(OP_CFG, 36'h0_0000_0A5B);
      drive_op(OP_WBASE, 36'h0_FEE0_0C00);
      @(negedge clk);
      release_all();
      chk_all("R8 over restore", 36'h0_FEE0_0D00, 32'hA5B, 1'b0);

      @(negedge clk);
      drive_op(OP_WBASE, 36'h0_FEE0_0800);
      @(negedge clk);
      release_all();
      chk_all("R8 working low bits R7", 36'h0_FEE0_0900, 32'h5B, 1'b0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule